// File: doc/BRIEF.md
# Multi-Rate Simulation Step Sequencer

This block paces a real-time circuit solver and links it to a controller that runs on a much slower time base. A free-running cycle counter splits time into fixed solver windows of `WIN_CYC` clocks. With the defaults, a 160 MHz clock and a 250 ns step give 40 clocks per window. The block raises a start strobe in the first cycle of every window, and every subsystem solver begins in that cycle. Each subsystem reports completion with a done pulse and presents its node-voltage and branch-current word in the same cycle. A done that has not come in by the last cycle of the window sets a sticky overrun flag.

A second counter groups `STEPS_PER_XCH` windows into one exchange period. With the defaults this is 400 steps, or 100 µs. In the last cycle of each period the block opens a valid/ready slot toward the controller's input FIFO and takes one control word. The new word drives the switch-control output from the next window onward. If the FIFO is empty, the block keeps the previous control word and a saturating miss counter records the miss. In the same cycle it takes a snapshot of the most recent result of every subsystem. It then streams the snapshot out, one word per subsystem, through a valid/ready port toward the output FIFO.

Top module: `sim_step_seq`

## Requirements
- R1: `step_start` is high for exactly one cycle in every `WIN_CYC` cycles. It is high in window cycle 0, which is the first cycle after reset is released and every `WIN_CYC` cycles after that.
- R2: `ctrl_in_ready` is high only in cycle `WIN_CYC-1` of step `STEPS_PER_XCH-1`. This is once every `WIN_CYC*STEPS_PER_XCH` cycles, and the first such cycle comes `WIN_CYC*STEPS_PER_XCH-1` cycles after reset release.
- R3: If `ctrl_in_valid` is high while `ctrl_in_ready` is high, `ctrl_in_data` appears on `ctrl_word` from the next cycle, which is a `step_start` cycle. It stays there until the next exchange.
- R4: `ctrl_in_valid` and `ctrl_in_data` outside the exchange cycle have no effect: `ctrl_word` does not change.
- R5: If `ctrl_in_valid` is low in an exchange cycle, `ctrl_word` keeps its value and `miss_count` rises by one from the next cycle. The count saturates at all ones.
- R6: Under reset (synchronous, active low) `ctrl_word` is all zeros (every switch off), `miss_count` is 0, `overrun` is 0 and `res_out_valid` is 0. Both counters restart, so the first cycle after release is window cycle 0.
- R7: If any subsystem has not pulsed `sub_done` in cycles 0 to `WIN_CYC-1` of a window, `overrun` rises in the next cycle and stays high until reset. A done in cycle `WIN_CYC-1` is still in time.
- R8: At each exchange cycle, the latest result word of every subsystem is captured, including a word whose done pulse arrives in that same cycle. From the next cycle the words are sent as `N_SUB` transfers, subsystem 0 first. Each word is held while `res_out_ready` is low.
- R9: An exchange that comes before the previous snapshot has been fully sent drops the unsent words and starts the new snapshot at subsystem 0.
- R10: A subsystem's result bus is only taken in a cycle where its `sub_done` bit is high. Values on the bus at other times never appear at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_start | output | 1 | Start strobe for all subsystems, window cycle 0 |
| sub_done | input | N_SUB | Per-subsystem completion pulse |
| sub_res | input | N_SUB*RES_W | Per-subsystem result word, subsystem i at bits i*RES_W upward |
| overrun | output | 1 | Sticky deadline-miss flag |
| ctrl_in_valid | input | 1 | Control FIFO holds a word |
| ctrl_in_ready | output | 1 | Control word is taken this cycle |
| ctrl_in_data | input | CTRL_W | Incoming control word |
| ctrl_word | output | CTRL_W | Control word applied to the solver |
| miss_count | output | MISS_W | Saturating count of exchanges with no control word |
| res_out_valid | output | 1 | Result word on offer |
| res_out_ready | input | 1 | Output FIFO accepts the word |
| res_out_data | output | RES_W | Result word |

## Verification
All results are due at fixed cycle offsets, counted from reset release:
- `step_start` is due in cycle 0 of each window, and `ctrl_in_ready` in the final cycle of each period.
- `ctrl_word` and `miss_count` change one cycle after the exchange cycle.
- `overrun` rises one cycle after the last cycle of the failing window.
- The first result word is offered one cycle after the exchange.

The bench keeps a cycle index. It drives inputs just after each rising edge and compares every output at the falling edge of the cycle in which that output is due. The stimulus includes:
- a done arriving in the window's last cycle, which must still count as in time and whose word must appear in the snapshot;
- a snapshot overwritten while blocked by `res_out_ready` low;
- the miss counter driven into saturation.

// File: rtl/sim_seq_pkg.sv
// Shared types for the step sequencer.
package sim_seq_pkg;
    // State of the result streamer.
    typedef enum logic [0:0] {
        EXP_IDLE = 1'b0,
        EXP_SEND = 1'b1
    } exp_state_t;
endpackage

// File: rtl/sim_step_timer.sv
// Window and step counters.
// Counts WIN_CYC clocks per solver window and STEPS_PER_XCH windows per
// exchange period. Assumes WIN_CYC >= 2.
module sim_step_timer #(
    parameter int WIN_CYC       = 40,
    parameter int STEPS_PER_XCH = 400
) (
    input  logic clk,
    input  logic rst_n,
    output logic step_start,
    output logic win_last,
    output logic xch_tick
);
    localparam int CYC_W  = $clog2(WIN_CYC);
    localparam int STEP_W = (STEPS_PER_XCH > 1) ? $clog2(STEPS_PER_XCH) : 1;
    localparam logic [CYC_W-1:0]  CYC_LAST  = CYC_W'(WIN_CYC - 1);
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEPS_PER_XCH - 1);

    logic [CYC_W-1:0]  cyc_q;
    logic [STEP_W-1:0] step_q;

    // Advance the cycle counter; wrap it and advance the step counter at window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q  <= '0;
            step_q <= '0;
        end else if (cyc_q == CYC_LAST) begin
            cyc_q  <= '0;
            step_q <= (step_q == STEP_LAST) ? '0 : step_q + 1'b1;
        end else begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    // Decode the window phases.
    always_comb begin
        step_start = (cyc_q == '0);
        win_last   = (cyc_q == CYC_LAST);
        xch_tick   = win_last && (step_q == STEP_LAST);
    end

    // R1: a window's last cycle is followed by a start cycle.
    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        win_last |=> step_start);
    // R1: the start strobe is never two cycles long.
    p_start_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        step_start |=> !step_start);
    // R2: the step index advances by one at every non-exchange window end.
    p_step_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (win_last && !xch_tick) |=> (step_q == $past(step_q) + 1'b1));
    // R2: the step index returns to zero after an exchange.
    p_step_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        xch_tick |=> (step_q == '0));
endmodule

// File: rtl/sim_done_monitor.sv
// Deadline monitor.
// Collects per-subsystem done pulses across a window and sets a sticky flag
// if any subsystem is still pending in the window's last cycle.
module sim_done_monitor #(
    parameter int N_SUB = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_last,
    input  logic [N_SUB-1:0] sub_done,
    output logic             overrun
);
    logic [N_SUB-1:0] got_q;
    logic             all_seen;

    // True when every subsystem is done, counting pulses in this cycle.
    always_comb all_seen = &(got_q | sub_done);

    // Gather done pulses; at window end clear them and latch a miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            got_q   <= '0;
            overrun <= 1'b0;
        end else if (win_last) begin
            got_q <= '0;
            if (!all_seen) overrun <= 1'b1;
        end else begin
            got_q <= got_q | sub_done;
        end
    end

    // R7: once raised, the flag stays raised.
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    // R7: a subsystem still pending at window end raises the flag.
    p_late_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (win_last && !all_seen) |=> overrun);
    // R7: the flag cannot rise except at a window end.
    p_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_last && !overrun) |=> !overrun);
endmodule

// File: rtl/sim_ctrl_holder.sv
// Control-word holder.
// Takes one control word per exchange period. It keeps the old word, and
// counts the miss, when the input FIFO is empty. Reset applies the
// all-switches-off word.
module sim_ctrl_holder #(
    parameter int CTRL_W = 32,
    parameter int MISS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xch_tick,
    input  logic              in_valid,
    input  logic [CTRL_W-1:0] in_data,
    output logic              in_ready,
    output logic [CTRL_W-1:0] ctrl_word,
    output logic [MISS_W-1:0] miss_count
);
    localparam logic [CTRL_W-1:0] CTRL_OFF = '0;
    localparam logic [MISS_W-1:0] MISS_MAX = '1;

    // Offer the slot only in the exchange cycle.
    always_comb in_ready = xch_tick;

    // Load a new word at exchange, or count the miss with saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_word  <= CTRL_OFF;
            miss_count <= '0;
        end else if (xch_tick) begin
            if (in_valid) begin
                ctrl_word <= in_data;
            end else if (miss_count != MISS_MAX) begin
                miss_count <= miss_count + 1'b1;
            end
        end
    end

    // R3: a word offered at exchange is applied in the next cycle.
    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (xch_tick && in_valid) |=> (ctrl_word == $past(in_data)));
    // R4: outside the exchange cycle the applied word does not change.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !xch_tick |=> $stable(ctrl_word));
    // R5: an empty FIFO at exchange keeps the word.
    p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (xch_tick && !in_valid) |=> $stable(ctrl_word));
    // R5: the miss count stays at its ceiling.
    p_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_count == MISS_MAX) |=> (miss_count == MISS_MAX));
endmodule

// File: rtl/sim_result_export.sv
// Result capture and streamer.
// Keeps the latest result of each subsystem, snapshots all of them at an
// exchange, and sends the snapshot one word per subsystem over valid/ready.
// A new exchange restarts the stream.
module sim_result_export
    import sim_seq_pkg::*;
#(
    parameter int N_SUB = 6,
    parameter int RES_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   xch_tick,
    input  logic [N_SUB-1:0]       sub_done,
    input  logic [N_SUB*RES_W-1:0] sub_res,
    input  logic                   out_ready,
    output logic                   out_valid,
    output logic [RES_W-1:0]       out_data
);
    localparam int IDX_W = (N_SUB > 1) ? $clog2(N_SUB) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_SUB - 1);

    logic [RES_W-1:0] bank_q  [N_SUB];
    logic [RES_W-1:0] snap    [N_SUB];
    logic [RES_W-1:0] frame_q [N_SUB];
    logic [IDX_W-1:0] idx_q;
    exp_state_t       state_q;

    for (genvar gi = 0; gi < N_SUB; gi++) begin : g_sub
        // Keep this subsystem's word from its most recent done pulse.
        always_ff @(posedge clk) begin
            if (!rst_n) bank_q[gi] <= '0;
            else if (sub_done[gi]) bank_q[gi] <= sub_res[gi*RES_W +: RES_W];
        end

        // Pass through a word that arrives in the snapshot cycle.
        always_comb snap[gi] = sub_done[gi] ? sub_res[gi*RES_W +: RES_W] : bank_q[gi];

        // Copy the snapshot into the send buffer at exchange.
        always_ff @(posedge clk) begin
            if (!rst_n) frame_q[gi] <= '0;
            else if (xch_tick) frame_q[gi] <= snap[gi];
        end
    end

    // Step through the buffer on each accepted transfer; restart at exchange.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= EXP_IDLE;
            idx_q   <= '0;
        end else if (xch_tick) begin
            state_q <= EXP_SEND;
            idx_q   <= '0;
        end else if (state_q == EXP_SEND && out_ready) begin
            if (idx_q == IDX_LAST) begin
                state_q <= EXP_IDLE;
                idx_q   <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Present the current buffer word.
    always_comb begin
        out_valid = (state_q == EXP_SEND);
        out_data  = frame_q[idx_q];
    end

    // R8: a stalled word stays on offer unchanged.
    p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !xch_tick) |=> (out_valid && $stable(out_data)));
    // R9: every exchange starts a fresh stream at subsystem 0.
    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        xch_tick |=> (out_valid && idx_q == '0));
    // R10: the stored word changes only when that subsystem is done.
    p_bank_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sub_done[0] |=> $stable(bank_q[0]));
endmodule

// File: rtl/sim_step_seq.sv
// Multi-rate step sequencer, top level.
// Issues the fixed-period solver start strobe and watches subsystem
// deadlines. Once per exchange period it swaps in a control word and
// streams out the latest results. Assumes the FIFOs on both sides follow
// a valid/ready handshake in the same clock domain.
module sim_step_seq #(
    parameter int WIN_CYC       = 40,
    parameter int STEPS_PER_XCH = 400,
    parameter int N_SUB         = 6,
    parameter int CTRL_W        = 32,
    parameter int RES_W         = 32,
    parameter int MISS_W        = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    output logic                   step_start,
    input  logic [N_SUB-1:0]       sub_done,
    input  logic [N_SUB*RES_W-1:0] sub_res,
    output logic                   overrun,
    input  logic                   ctrl_in_valid,
    output logic                   ctrl_in_ready,
    input  logic [CTRL_W-1:0]      ctrl_in_data,
    output logic [CTRL_W-1:0]      ctrl_word,
    output logic [MISS_W-1:0]      miss_count,
    output logic                   res_out_valid,
    input  logic                   res_out_ready,
    output logic [RES_W-1:0]       res_out_data
);
    logic win_last;
    logic xch_tick;

    sim_step_timer #(
        .WIN_CYC      (WIN_CYC),
        .STEPS_PER_XCH(STEPS_PER_XCH)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_start(step_start),
        .win_last  (win_last),
        .xch_tick  (xch_tick)
    );

    sim_done_monitor #(
        .N_SUB(N_SUB)
    ) u_deadline (
        .clk     (clk),
        .rst_n   (rst_n),
        .win_last(win_last),
        .sub_done(sub_done),
        .overrun (overrun)
    );

    sim_ctrl_holder #(
        .CTRL_W(CTRL_W),
        .MISS_W(MISS_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .xch_tick  (xch_tick),
        .in_valid  (ctrl_in_valid),
        .in_data   (ctrl_in_data),
        .in_ready  (ctrl_in_ready),
        .ctrl_word (ctrl_word),
        .miss_count(miss_count)
    );

    sim_result_export #(
        .N_SUB(N_SUB),
        .RES_W(RES_W)
    ) u_export (
        .clk      (clk),
        .rst_n    (rst_n),
        .xch_tick (xch_tick),
        .sub_done (sub_done),
        .sub_res  (sub_res),
        .out_ready(res_out_ready),
        .out_valid(res_out_valid),
        .out_data (res_out_data)
    );

    // R2: the control slot opens only alongside a window's last cycle.
    p_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_in_ready |-> !step_start);
    // R6: the first cycle after reset release is a start cycle.
    p_first_r6: assert property (@(posedge clk)
        !rst_n |=> step_start);
endmodule

// File: tb/sim_step_seq_test.sv
`timescale 1ns/100ps
// Scoreboard bench: the model pushes expected result words into a queue at
// every exchange, and a monitor pops and compares them as they are sent.
module sim_step_seq_test;
    localparam int WIN   = 8;
    localparam int STEPS = 4;
    localparam int PER   = WIN * STEPS;
    localparam int NS    = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          step_start;
    logic [NS-1:0] sub_done;
    logic [NS*16-1:0] sub_res;
    logic          overrun;
    logic          in_valid;
    logic          in_ready;
    logic [15:0]   in_data;
    logic [15:0]   ctrl_word;
    logic [1:0]    miss_count;
    logic          out_valid;
    logic          out_ready;
    logic [15:0]   out_data;

    int checks = 0;
    int errors = 0;
    bit running = 1'b0;

    logic [15:0] expq[$];
    logic [15:0] bank_m [NS];
    logic [NS-1:0] got_m;
    logic [15:0] ectrl;
    logic [1:0]  emiss;
    logic        eovr;

    always #2.5 clk = ~clk;

    sim_step_seq #(
        .WIN_CYC(WIN), .STEPS_PER_XCH(STEPS), .N_SUB(NS),
        .CTRL_W(16), .RES_W(16), .MISS_W(2)
    ) uut (
        .clk(clk), .rst_n(rst_n), .step_start(step_start),
        .sub_done(sub_done), .sub_res(sub_res), .overrun(overrun),
        .ctrl_in_valid(in_valid), .ctrl_in_ready(in_ready), .ctrl_in_data(in_data),
        .ctrl_word(ctrl_word), .miss_count(miss_count),
        .res_out_valid(out_valid), .res_out_ready(out_ready), .res_out_data(out_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h time=%0t", req, act, exp, $time);
        end
    endtask

    // Stimulus for cycle tt: done timing, control FIFO and output-side ready.
    task automatic drive(input int tt);
        int e = tt / PER;
        int w = tt / WIN;
        int c = tt % WIN;
        for (int i = 0; i < NS; i++) begin
            int  dly = (i == 0) ? 2 : (i == 1) ? 3 : ((e >= 1) ? WIN - 1 : 5);
            bit  en  = !(i == 1 && w == 25);
            bit  dn  = en && (c == dly);
            sub_done[i] = dn;
            sub_res[i*16 +: 16] = dn ? {w[7:0], i[7:0]} : 16'hFFFF;
        end
        in_valid = (e == 0) || (e == 5);
        in_data  = (e == 0) ? 16'h00A1 : (e == 5) ? 16'h005C : 16'hEEEE;
        out_ready = (e == 1) ? tt[0] : (e == 3) ? 1'b0 : 1'b1;
    endtask

    // Compare the cycle-indexed outputs.
    task automatic check_cycle(input int tt);
        if (tt == 0) chk("R6 first start", step_start, 1'b1);
        chk("R1 step_start", step_start, (tt % WIN) == 0);
        chk("R2 R4 ctrl_in_ready", in_ready, (tt % PER) == PER - 1);
        chk("R3 R4 ctrl_word", ctrl_word, ectrl);
        chk("R5 miss_count", miss_count, emiss);
        chk("R7 overrun", overrun, eovr);
    endtask

    // Advance the expected state after this cycle's edge.
    task automatic update_model(input int tt);
        if ((tt % WIN) == WIN - 1) begin
            if (!(&(got_m | sub_done))) eovr = 1'b1;
            got_m = '0;
        end else begin
            got_m = got_m | sub_done;
        end
        for (int i = 0; i < NS; i++)
            if (sub_done[i]) bank_m[i] = sub_res[i*16 +: 16];
        if ((tt % PER) == PER - 1) begin
            expq.delete();   // R9: an unsent snapshot is dropped
            for (int i = 0; i < NS; i++) expq.push_back(bank_m[i]);
            if (in_valid) ectrl = in_data;
            else if (emiss != 2'b11) emiss = emiss + 1'b1;
        end
    endtask

    // Monitor: valid must match pending words; accepted words must match the queue.
    always @(negedge clk) begin
        if (running) begin
            chk("R8 res_out_valid", out_valid, expq.size() > 0);
            if (out_valid && out_ready && expq.size() > 0) begin
                chk("R8 R9 R10 res_out_data", out_data, expq.pop_front());
            end
        end
    end

    initial begin
        rst_n = 1'b0; sub_done = '0; sub_res = '1;
        in_valid = 1'b0; in_data = 16'hEEEE; out_ready = 1'b0;
        ectrl = '0; emiss = '0; eovr = 1'b0; got_m = '0;
        for (int i = 0; i < NS; i++) bank_m[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R6 reset ctrl_word", ctrl_word, 16'h0000);
        chk("R6 reset miss_count", miss_count, 2'd0);
        chk("R6 reset overrun", overrun, 1'b0);
        chk("R6 reset res_out_valid", out_valid, 1'b0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        running = 1'b1;
        for (int tt = 0; tt < 300; tt++) begin
            drive(tt);
            @(negedge clk);
            check_cycle(tt);
            #1 update_model(tt);
            @(posedge clk); #1;
        end
        chk("R8 all words sent", expq.size(), 0);
        chk("R5 saturated", miss_count, 2'b11);
        chk("R7 still set", overrun, 1'b1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule